// File: doc/BRIEF.md
# I2C Event Status Flag Controller

This block holds the event status of an I2C interface that can act as master or slave. It decides, cycle by cycle, when each flag rises and falls. The bus engine sends it single-cycle strobes for the events it sees: a start that it drove, start and stop conditions seen on the wire, a 10-bit header sent, acknowledge pulses after transmitted or received bytes, address and general-call hits, arbitration loss and the end of a DMA transfer. Software activity reaches it as strobes for a status read, a data read, a data write and any other register access.

Most flags clear only through a two-step sequence. A status read arms the sequence and the next data-register access completes it. The block presents the flags as one status byte. It raises an event interrupt when the interrupt enable is set, and a clock-stretch request that the pad logic uses to hold SCL low while software still owes a response. Every pin is a plain level or a single-cycle strobe. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `i2c_evflag_ctrl`

## Requirements
- R1: All flags are registered and are 0 after reset. The status byte is laid out as follows: bit 6 header sent, bit 5 transmit direction, bit 4 bus busy, bit 3 byte finished, bit 2 address matched, bit 1 master, bit 0 start generated. Bit 7 always reads 0. A flag changes in the first cycle after the clock edge that samples its cause.
- R2: Bus busy sets on bus_start_i and clears on bus_stop_i, and the set wins when both occur together. It follows the bus whether or not pe_i is 1.
- R3: When start_gen_i and start_req_i are both 1 while bus busy is 0, the start flag and the master flag both set. When bus busy is already 1, neither flag sets.
- R4: The master flag clears on bus_stop_i or arb_lost_i.
- R5: The header flag sets on hdr_sent_i. It clears on an armed data write or on bus_stop_i.
- R6: tx_ack_i sets byte finished and transmit direction. rx_ack_i sets byte finished and clears transmit direction, but only when ack_en_i is 1; with ack_en_i at 0 it has no effect. When tx_ack_i and rx_ack_i occur together, the transmit direction is set.
- R7: Byte finished clears on dma_done_i. It also clears on an armed data access in the matching direction: a write when transmit direction is 1, a read when it is 0. An access in the other direction leaves it set. Transmit direction clears whenever the byte-finished clear condition holds, and also on bus_stop_i or arb_lost_i.
- R8: The address flag sets on addr_hit_i or gcall_hit_i. A status read alone clears it.
- R9: sr_rd_i arms the two-step clear. The next dr_rd_i or dr_wr_i uses up the arming. other_acc_i, any set event of the header, byte, address or start flags, or pe_i at 0 disarms it. A data access made while not armed clears nothing. The start flag clears on an armed data write.
- R10: When a set event and a clear condition for the same flag fall in the same cycle, the flag ends up 1.
- R11: While pe_i is 0, every flag except bus busy is forced to 0 and set events are ignored.
- R12: scl_hold_o is 1 exactly when byte finished, address matched or start generated is 1.
- R13: irq_o is 1 exactly when ite_i is 1 and at least one of header sent, byte finished, address matched or start generated is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pe_i | input | 1 | Peripheral enable |
| ite_i | input | 1 | Event interrupt enable |
| ack_en_i | input | 1 | Acknowledge enabled for received bytes |
| start_req_i | input | 1 | Software start request is pending |
| start_gen_i | input | 1 | Engine drove a start condition |
| bus_start_i | input | 1 | Start condition seen on the bus |
| bus_stop_i | input | 1 | Stop condition seen on the bus |
| hdr_sent_i | input | 1 | First byte of a 10-bit address sent |
| tx_ack_i | input | 1 | Acknowledge pulse after a transmitted byte |
| rx_ack_i | input | 1 | Acknowledge pulse after a received byte |
| addr_hit_i | input | 1 | Own address matched |
| gcall_hit_i | input | 1 | General call address matched |
| arb_lost_i | input | 1 | Arbitration lost |
| dma_done_i | input | 1 | DMA transfer complete |
| sr_rd_i | input | 1 | Status register read strobe |
| dr_rd_i | input | 1 | Data register read strobe |
| dr_wr_i | input | 1 | Data register write strobe |
| other_acc_i | input | 1 | Access to any other register |
| status_o | output | 8 | Packed status byte |
| irq_o | output | 1 | Event interrupt |
| scl_hold_o | output | 1 | Request to hold SCL low |

## Verification
Two situations are hard to reach from the ports. The first is an armed data access that lands in the same cycle as a set event, where the set must win. The second is a direction-mismatched access that must use up the arming without clearing byte finished. Directed steps build each of them with an explicit status read, a data access and a new event in one cycle. A fixed-seed random phase then drives mostly sparse strobes with a rare disable, and compares every cycle against a bench model. That mix makes interleavings of arming, disarming and bus stops far more common than real traffic would.

// File: rtl/i2c_evflag_pkg.sv
package i2c_evflag_pkg;
  localparam int STATUS_W  = 8;
  localparam int NUM_FLAGS = 7;
  localparam int F_SB   = 0;
  localparam int F_MST  = 1;
  localparam int F_ADR  = 2;
  localparam int F_BTF  = 3;
  localparam int F_BUSY = 4;
  localparam int F_DIR  = 5;
  localparam int F_HDR  = 6;
  localparam logic [NUM_FLAGS-1:0] IRQ_MASK  =
    (NUM_FLAGS'(1) << F_HDR) | (NUM_FLAGS'(1) << F_BTF) |
    (NUM_FLAGS'(1) << F_ADR) | (NUM_FLAGS'(1) << F_SB);
  localparam logic [NUM_FLAGS-1:0] HOLD_MASK =
    (NUM_FLAGS'(1) << F_BTF) | (NUM_FLAGS'(1) << F_ADR) |
    (NUM_FLAGS'(1) << F_SB);
endpackage

// File: rtl/i2c_evflag_cell.sv
module i2c_evflag_cell #(
  parameter bit KEEP_WHEN_OFF = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_nx;

  always_comb begin
    if (!en && !KEEP_WHEN_OFF) q_nx = 1'b0;
    else if (set)              q_nx = 1'b1;
    else if (clr)              q_nx = 1'b0;
    else                       q_nx = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nx;
  end
endmodule

// File: rtl/i2c_evflag_arm.sv
module i2c_evflag_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sr_rd,
  input  logic data_acc,
  input  logic other_acc,
  input  logic new_event,
  output logic armed
);
  logic armed_nx;

  always_comb begin
    if (!en || new_event || other_acc || data_acc) armed_nx = 1'b0;
    else if (sr_rd)                                armed_nx = 1'b1;
    else                                           armed_nx = armed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= armed_nx;
  end
endmodule

// File: rtl/i2c_evflag_out.sv
module i2c_evflag_out #(
  parameter int N = 7,
  parameter logic [N-1:0] IRQ_SEL  = '0,
  parameter logic [N-1:0] HOLD_SEL = '0
) (
  input  logic [N-1:0] flags,
  input  logic         ite,
  output logic         irq,
  output logic         hold
);
  assign irq  = ite && (|(flags & IRQ_SEL));
  assign hold = |(flags & HOLD_SEL);
endmodule

// File: rtl/i2c_evflag_ctrl.sv
module i2c_evflag_ctrl
  import i2c_evflag_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pe_i,
  input  logic                ite_i,
  input  logic                ack_en_i,
  input  logic                start_req_i,
  input  logic                start_gen_i,
  input  logic                bus_start_i,
  input  logic                bus_stop_i,
  input  logic                hdr_sent_i,
  input  logic                tx_ack_i,
  input  logic                rx_ack_i,
  input  logic                addr_hit_i,
  input  logic                gcall_hit_i,
  input  logic                arb_lost_i,
  input  logic                dma_done_i,
  input  logic                sr_rd_i,
  input  logic                dr_rd_i,
  input  logic                dr_wr_i,
  input  logic                other_acc_i,
  output logic [STATUS_W-1:0] status_o,
  output logic                irq_o,
  output logic                scl_hold_o
);
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] set_v;
  logic [NUM_FLAGS-1:0] clr_v;
  logic armed;
  logic sb_ev, rx_ev, btf_clr, armed_wr, any_ev;

  // start only counts when the bus was idle before this cycle
  assign sb_ev    = start_req_i && start_gen_i && !flag_q[F_BUSY];
  assign rx_ev    = rx_ack_i && ack_en_i;
  assign armed_wr = armed && dr_wr_i;
  assign btf_clr  = dma_done_i ||
                    (armed && (flag_q[F_DIR] ? dr_wr_i : dr_rd_i));
  assign any_ev   = pe_i && (hdr_sent_i || tx_ack_i || rx_ev ||
                             addr_hit_i || gcall_hit_i || sb_ev);

  always_comb begin
    set_v = '0;
    clr_v = '0;
    set_v[F_SB]   = sb_ev;
    clr_v[F_SB]   = armed_wr;
    set_v[F_MST]  = sb_ev;
    clr_v[F_MST]  = bus_stop_i || arb_lost_i;
    set_v[F_ADR]  = addr_hit_i || gcall_hit_i;
    clr_v[F_ADR]  = sr_rd_i;
    set_v[F_BTF]  = tx_ack_i || rx_ev;
    clr_v[F_BTF]  = btf_clr;
    set_v[F_BUSY] = bus_start_i;
    clr_v[F_BUSY] = bus_stop_i;
    set_v[F_DIR]  = tx_ack_i;
    clr_v[F_DIR]  = rx_ev || btf_clr || bus_stop_i || arb_lost_i;
    set_v[F_HDR]  = hdr_sent_i;
    clr_v[F_HDR]  = armed_wr || bus_stop_i;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    i2c_evflag_cell #(
      .KEEP_WHEN_OFF(i == F_BUSY)
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (pe_i),
      .set   (set_v[i]),
      .clr   (clr_v[i]),
      .q     (flag_q[i])
    );
  end

  i2c_evflag_arm u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (pe_i),
    .sr_rd     (sr_rd_i),
    .data_acc  (dr_rd_i || dr_wr_i),
    .other_acc (other_acc_i),
    .new_event (any_ev),
    .armed     (armed)
  );

  i2c_evflag_out #(
    .N        (NUM_FLAGS),
    .IRQ_SEL  (IRQ_MASK),
    .HOLD_SEL (HOLD_MASK)
  ) u_out (
    .flags (flag_q),
    .ite   (ite_i),
    .irq   (irq_o),
    .hold  (scl_hold_o)
  );

  assign status_o = {{(STATUS_W-NUM_FLAGS){1'b0}}, flag_q};
endmodule

// File: rtl/i2c_evflag_chk.sv
module i2c_evflag_chk
  import i2c_evflag_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                pe_i,
  input logic                ite_i,
  input logic                start_req_i,
  input logic                start_gen_i,
  input logic                bus_start_i,
  input logic                bus_stop_i,
  input logic                addr_hit_i,
  input logic                gcall_hit_i,
  input logic                arb_lost_i,
  input logic                sr_rd_i,
  input logic [STATUS_W-1:0] status_o,
  input logic                irq_o,
  input logic                scl_hold_o
);
  AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !status_o[STATUS_W-1]); // R1

  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start_i |=> status_o[F_BUSY]); // R2

  AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop_i && !bus_start_i |=> !status_o[F_BUSY]); // R2

  AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pe_i && start_req_i && start_gen_i && !status_o[F_BUSY]
      |=> status_o[F_SB] && status_o[F_MST]); // R3

  AST_ARB_DROPS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_i && !(start_req_i && start_gen_i) |=> !status_o[F_MST]); // R4

  AST_ADR_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    sr_rd_i && !addr_hit_i && !gcall_hit_i |=> !status_o[F_ADR]); // R8

  AST_OFF_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_i |=> (status_o[NUM_FLAGS-1:0] & ~(NUM_FLAGS'(1) << F_BUSY)) == '0); // R11

  AST_HOLD_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[F_BTF] || status_o[F_ADR] || status_o[F_SB] |-> scl_hold_o); // R12

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ite_i |-> !irq_o); // R13
endmodule

bind i2c_evflag_ctrl i2c_evflag_chk u_chk (.*);

// File: tb/sim_i2c_evflag_ctrl.sv
module sim_i2c_evflag_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pe, ite, ack_en, start_req, start_gen, bus_start, bus_stop;
  logic hdr_sent, tx_ack, rx_ack, addr_hit, gcall_hit, arb_lost, dma_done;
  logic sr_rd, dr_rd, dr_wr, other_acc;
  logic [7:0] status;
  logic irq, scl_hold;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model of the flags
  logic m_hdr, m_dir, m_busy, m_btf, m_adr, m_mst, m_sb, m_arm;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_evflag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pe_i(pe), .ite_i(ite), .ack_en_i(ack_en),
    .start_req_i(start_req), .start_gen_i(start_gen),
    .bus_start_i(bus_start), .bus_stop_i(bus_stop), .hdr_sent_i(hdr_sent),
    .tx_ack_i(tx_ack), .rx_ack_i(rx_ack), .addr_hit_i(addr_hit),
    .gcall_hit_i(gcall_hit), .arb_lost_i(arb_lost), .dma_done_i(dma_done),
    .sr_rd_i(sr_rd), .dr_rd_i(dr_rd), .dr_wr_i(dr_wr),
    .other_acc_i(other_acc), .status_o(status), .irq_o(irq),
    .scl_hold_o(scl_hold)
  );

  function automatic logic [7:0] m_byte();
    return {1'b0, m_hdr, m_dir, m_busy, m_btf, m_adr, m_mst, m_sb};
  endfunction

  function automatic logic m_irq();
    return ite && (m_hdr || m_btf || m_adr || m_sb);
  endfunction

  function automatic logic m_hold();
    return m_btf || m_adr || m_sb;
  endfunction

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic clear_strobes();
    start_gen = 0; bus_start = 0; bus_stop = 0; hdr_sent = 0;
    tx_ack = 0; rx_ack = 0; addr_hit = 0; gcall_hit = 0; arb_lost = 0;
    dma_done = 0; sr_rd = 0; dr_rd = 0; dr_wr = 0; other_acc = 0;
  endtask

  // advance one clock; the model follows the requirement rules
  task automatic cyc();
    logic sbev, rxev, bclr, awr, ev;
    logic n_hdr, n_dir, n_busy, n_btf, n_adr, n_mst, n_sb, n_arm;
    sbev = start_req && start_gen && !m_busy;
    rxev = rx_ack && ack_en;
    awr  = m_arm && dr_wr;
    bclr = dma_done || (m_arm && (m_dir ? dr_wr : dr_rd));
    ev   = pe && (hdr_sent || tx_ack || rxev || addr_hit || gcall_hit || sbev);
    n_busy = bus_start ? 1'b1 : (bus_stop ? 1'b0 : m_busy);
    n_hdr = !pe ? 1'b0 : hdr_sent ? 1'b1 : (awr || bus_stop) ? 1'b0 : m_hdr;
    n_dir = !pe ? 1'b0 : tx_ack ? 1'b1 :
            (rxev || bclr || bus_stop || arb_lost) ? 1'b0 : m_dir;
    n_btf = !pe ? 1'b0 : (tx_ack || rxev) ? 1'b1 : bclr ? 1'b0 : m_btf;
    n_adr = !pe ? 1'b0 : (addr_hit || gcall_hit) ? 1'b1 : sr_rd ? 1'b0 : m_adr;
    n_mst = !pe ? 1'b0 : sbev ? 1'b1 : (bus_stop || arb_lost) ? 1'b0 : m_mst;
    n_sb  = !pe ? 1'b0 : sbev ? 1'b1 : awr ? 1'b0 : m_sb;
    n_arm = (!pe || ev || other_acc || dr_rd || dr_wr) ? 1'b0 :
            sr_rd ? 1'b1 : m_arm;
    @(posedge clk);
    #1;
    m_hdr = n_hdr; m_dir = n_dir; m_busy = n_busy; m_btf = n_btf;
    m_adr = n_adr; m_mst = n_mst; m_sb = n_sb; m_arm = n_arm;
    @(negedge clk);
    clear_strobes();
  endtask

  task automatic expect_st(input string req, input logic [7:0] exp);
    check(req, status, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    pe = 0; ite = 0; ack_en = 0; start_req = 0;
    clear_strobes();
    m_hdr = 0; m_dir = 0; m_busy = 0; m_btf = 0;
    m_adr = 0; m_mst = 0; m_sb = 0; m_arm = 0;
    repeat (3) @(negedge clk);
    check("R1 reset status", status, 8'h00);
    check("R1 reset irq/hold", {6'd0, irq, scl_hold}, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R2 busy tracks while disabled, R11 nothing else moves
    bus_start = 1; tx_ack = 1; cyc(); expect_st("R2 R11 busy while off", 8'h10);
    bus_stop = 1; cyc(); expect_st("R2 stop clears busy", 8'h00);

    // R3 start on idle bus, R12 R13 outputs
    pe = 1; ite = 1; start_req = 1;
    start_gen = 1; bus_start = 1; cyc(); expect_st("R3 start+master", 8'h13);
    check("R12 hold on start", {7'd0, scl_hold}, 8'h01);
    check("R13 irq on start", {7'd0, irq}, 8'h01);
    start_req = 0;
    sr_rd = 1; cyc(); dr_wr = 1; cyc(); expect_st("R9 armed write clears start", 8'h12);

    // R5 header flag
    hdr_sent = 1; cyc(); expect_st("R5 header set", 8'h52);
    sr_rd = 1; cyc(); dr_wr = 1; cyc(); expect_st("R5 header clear", 8'h12);

    // R6 R7 transmit byte
    tx_ack = 1; cyc(); expect_st("R6 tx ack", 8'h3A);
    sr_rd = 1; cyc(); dr_rd = 1; cyc(); expect_st("R7 mismatched read keeps", 8'h3A);
    dr_wr = 1; cyc(); expect_st("R9 unarmed write keeps", 8'h3A);
    sr_rd = 1; cyc(); other_acc = 1; cyc(); dr_wr = 1; cyc();
    expect_st("R9 other access disarms", 8'h3A);
    sr_rd = 1; cyc(); dr_wr = 1; cyc(); expect_st("R7 armed write clears", 8'h12);
    tx_ack = 1; cyc(); dma_done = 1; cyc(); expect_st("R7 dma clears", 8'h12);

    // R6 receive byte
    rx_ack = 1; cyc(); expect_st("R6 rx no ack ignored", 8'h12);
    ack_en = 1; rx_ack = 1; cyc(); expect_st("R6 rx ack sets", 8'h1A);
    sr_rd = 1; cyc(); dr_rd = 1; cyc(); expect_st("R7 armed read clears", 8'h12);

    // R10 set wins over armed clear
    tx_ack = 1; cyc(); sr_rd = 1; cyc();
    dr_wr = 1; tx_ack = 1; cyc(); expect_st("R10 set wins", 8'h3A);
    dma_done = 1; cyc();

    // R4 arbitration, R3 no start on busy bus
    arb_lost = 1; cyc(); expect_st("R4 arb loss", 8'h10);
    start_req = 1; start_gen = 1; cyc(); expect_st("R3 busy blocks start", 8'h10);
    start_req = 0;
    bus_stop = 1; cyc(); expect_st("R2 stop", 8'h00);

    // R8 address flag
    ite = 0; addr_hit = 1; cyc(); expect_st("R8 addr hit", 8'h04);
    check("R13 irq gated", {7'd0, irq}, 8'h00);
    check("R12 hold on addr", {7'd0, scl_hold}, 8'h01);
    sr_rd = 1; cyc(); expect_st("R8 read clears", 8'h00);
    ite = 1; gcall_hit = 1; cyc(); expect_st("R8 general call", 8'h04);
    sr_rd = 1; cyc(); expect_st("R8 read clears gc", 8'h00);
    check("R12 hold released", {7'd0, scl_hold}, 8'h00);

    // R11 disable
    tx_ack = 1; hdr_sent = 1; cyc(); pe = 0; cyc(); expect_st("R11 disable", 8'h00);
    tx_ack = 1; cyc(); expect_st("R11 ignored while off", 8'h00);
    pe = 1; cyc();

    // random phase against the model
    void'($urandom(seed));
    for (int i = 0; i < RAND_CYCLES; i++) begin
      pe        = ($urandom_range(0, 99) > 2);
      ite       = $urandom_range(0, 1);
      ack_en    = ($urandom_range(0, 3) != 0);
      start_req = $urandom_range(0, 1);
      start_gen = ($urandom_range(0, 9) == 0);
      bus_start = ($urandom_range(0, 11) == 0);
      bus_stop  = ($urandom_range(0, 13) == 0);
      hdr_sent  = ($urandom_range(0, 15) == 0);
      tx_ack    = ($urandom_range(0, 7) == 0);
      rx_ack    = ($urandom_range(0, 7) == 0);
      addr_hit  = ($urandom_range(0, 11) == 0);
      gcall_hit = ($urandom_range(0, 19) == 0);
      arb_lost  = ($urandom_range(0, 19) == 0);
      dma_done  = ($urandom_range(0, 19) == 0);
      sr_rd     = ($urandom_range(0, 3) == 0);
      dr_rd     = ($urandom_range(0, 4) == 0);
      dr_wr     = ($urandom_range(0, 4) == 0);
      other_acc = ($urandom_range(0, 15) == 0);
      cyc();
      check("R7/R9/R10 random status", status, m_byte());
      check("R12/R13 random outputs", {6'd0, irq, scl_hold},
            {6'd0, m_irq(), m_hold()});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule